// File: doc/BRIEF.md
# Two-Stage Watchdog Timer

This block is a memory-mapped watchdog that supervises software by comparing a free-running system tick count, supplied from outside, against a deadline register. Software reaches it through two independent register windows. A small refresh window only accepts "I am alive" writes. A control window holds the enable and status bits, the timeout length and the deadline itself. Both windows also carry a fixed identification word.

When the deadline passes without a refresh, the watchdog enters its first stage. It sets a warning flag, raises an interrupt and pushes the deadline one timeout further out. If that second deadline also passes without a refresh, it sets the second flag and raises a reset request. The reset request stays high until the block itself is reset. A refresh from either window moves the deadline to the current count plus the timeout and clears both flags. With no refresh at all, the time from a refresh to the reset request is therefore twice the timeout value in ticks.

All read data and both outputs are registered. A read returns the addressed register one clock after the address is presented. Writes take effect at the clock edge where the write strobe is high.

Top module: `wdog2_top`

## Requirements
- R1: After reset, enable, both stage flags, the timeout register, the deadline register, `irq_o` and `wdt_reset_o` are all zero.
- R2: A write to offset 0x000 of the refresh window sets the deadline to `sys_count` + timeout and clears both stage flags. The data bus plays no part.
- R3: A write to the control/status word (control window offset 0x000) takes enable from data bit 0 and also acts as a refresh (R2). Data bits 1 and 2 are ignored, so the flags cannot be set by software.
- R4: While enabled, when `sys_count` >= deadline and the first flag is clear, the first flag is set and the deadline is reloaded with `sys_count` + timeout. `irq_o` is high exactly while the first flag and enable are both set, and it is visible after the same edge.
- R5: While enabled, when `sys_count` >= deadline and the first flag is already set, the second flag is set. With no refresh, the reset request appears at the edge where `sys_count` reaches refresh count + 2 × timeout.
- R6: `wdt_reset_o` rises with the second flag and then stays high through refreshes and disabling, until block reset.
- R7: While enable is clear, neither flag can be set, whatever the count.
- R8: A write to control offset 0x010 loads the deadline directly. It is not a refresh and leaves both flags unchanged.
- R9: The timeout register at control offset 0x008 is written and read back. Control/status reads return enable at bit 0, the first flag at bit 1 and the second flag at bit 2. All reads have one cycle of latency.
- R10: Offset 0xFCC in both windows reads the fixed identification value, and writes to it have no effect. Unmapped offsets read zero.
- R11: A refresh in the same cycle as an expiry wins: neither flag changes, and the deadline becomes count + timeout.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ref_wr | input | 1 | Refresh-window write strobe |
| ref_addr | input | 12 | Refresh-window byte offset |
| ref_rdata | output | DW | Refresh-window read data, one cycle after address |
| ctl_wr | input | 1 | Control-window write strobe |
| ctl_addr | input | 12 | Control-window byte offset |
| ctl_wdata | input | DW | Control-window write data |
| ctl_rdata | output | DW | Control-window read data, one cycle after address |
| sys_count | input | CW | Free-running system tick count |
| irq_o | output | 1 | First-stage alert interrupt |
| wdt_reset_o | output | 1 | Second-stage reset request, sticky |

## Verification
Every cycle, the assertions check these rules:
- A refresh clears both flags.
- A deadline write leaves the flags alone.
- No flag moves while the watchdog is disabled.
- The second flag only ever follows the first.
- The reset request never drops once raised.

The exact tick on which each stage fires can only be shown by the bench scenarios, which sweep timeout values and start counts and compare against refresh + timeout and refresh + 2 × timeout. The same applies to the refresh-versus-expiry priority, the read-back layout and the sticky reset across refresh and disable.

// File: rtl/wdog2_pkg.sv
package wdog2_pkg;
  localparam int unsigned REG_AW = 12;

  localparam logic [REG_AW-1:0] OFS_REFRESH = 12'h000;
  localparam logic [REG_AW-1:0] OFS_CTRL    = 12'h000;
  localparam logic [REG_AW-1:0] OFS_TIMEOUT = 12'h008;
  localparam logic [REG_AW-1:0] OFS_DEADLN  = 12'h010;
  localparam logic [REG_AW-1:0] OFS_IDENT   = 12'hFCC;

  localparam int unsigned BIT_EN  = 0;
  localparam int unsigned BIT_ST1 = 1;
  localparam int unsigned BIT_ST2 = 2;

  typedef struct packed {
    logic st2;
    logic st1;
    logic en;
  } wd_state_t;
endpackage

// File: rtl/wdog2_regs.sv
module wdog2_regs
  import wdog2_pkg::*;
#(
  parameter int unsigned DW     = 32,
  parameter int unsigned CW     = 32,
  parameter int unsigned OW     = 32,
  parameter logic [DW-1:0] ID_VAL = 32'h0001_5A3B
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ref_wr,
  input  logic [REG_AW-1:0] ref_addr,
  output logic [DW-1:0]     ref_rdata,
  input  logic              ctl_wr,
  input  logic [REG_AW-1:0] ctl_addr,
  input  logic [DW-1:0]     ctl_wdata,
  output logic [DW-1:0]     ctl_rdata,
  input  wd_state_t         state_i,
  input  logic [CW-1:0]     deadline_i,
  output logic [OW-1:0]     timeout_o,
  output logic              refresh_o,
  output logic              en_wr_o,
  output logic              en_val_o,
  output logic              dl_wr_o,
  output logic [CW-1:0]     dl_val_o
);
  logic ref_hit, ctl_hit, tmo_hit;
  logic [OW-1:0] timeout_q;

  assign ref_hit   = ref_wr && (ref_addr == OFS_REFRESH);
  assign ctl_hit   = ctl_wr && (ctl_addr == OFS_CTRL);
  assign tmo_hit   = ctl_wr && (ctl_addr == OFS_TIMEOUT);
  assign refresh_o = ref_hit || ctl_hit;
  assign en_wr_o   = ctl_hit;
  assign en_val_o  = ctl_wdata[BIT_EN];
  assign dl_wr_o   = ctl_wr && (ctl_addr == OFS_DEADLN);
  assign dl_val_o  = ctl_wdata[CW-1:0];
  assign timeout_o = timeout_q;

  always_ff @(posedge clk) begin
    if (rst) timeout_q <= '0;
    else if (tmo_hit) timeout_q <= ctl_wdata[OW-1:0];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ref_rdata <= '0;
      ctl_rdata <= '0;
    end else begin
      ref_rdata <= (ref_addr == OFS_IDENT) ? ID_VAL : '0;
      case (ctl_addr)
        OFS_CTRL: begin
          ctl_rdata          <= '0;
          ctl_rdata[BIT_EN]  <= state_i.en;
          ctl_rdata[BIT_ST1] <= state_i.st1;
          ctl_rdata[BIT_ST2] <= state_i.st2;
        end
        OFS_TIMEOUT: ctl_rdata <= DW'(timeout_q);
        OFS_DEADLN:  ctl_rdata <= DW'(deadline_i);
        OFS_IDENT:   ctl_rdata <= ID_VAL;
        default:     ctl_rdata <= '0;
      endcase
    end
  end

  p_timeout_write_r9: assert property (@(posedge clk) disable iff (rst)
    tmo_hit |=> timeout_q == $past(ctl_wdata[OW-1:0]));

  p_ident_read_r10: assert property (@(posedge clk) disable iff (rst)
    (ctl_addr == OFS_IDENT) |=> ctl_rdata == ID_VAL);
endmodule

// File: rtl/wdog2_timer.sv
module wdog2_timer
  import wdog2_pkg::*;
#(
  parameter int unsigned CW = 32,
  parameter int unsigned OW = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [CW-1:0] cnt_i,
  input  logic [OW-1:0] timeout_i,
  input  logic          refresh_i,
  input  logic          en_wr_i,
  input  logic          en_val_i,
  input  logic          dl_wr_i,
  input  logic [CW-1:0] dl_val_i,
  output wd_state_t     state_o,
  output logic [CW-1:0] deadline_o,
  output logic          irq_o,
  output logic          wdt_reset_o
);
  wd_state_t st_q, st_n;
  logic [CW-1:0] dl_q, dl_n, reload;
  logic hit, irq_q, rst_q;

  assign hit    = st_q.en && (cnt_i >= dl_q);
  assign reload = cnt_i + CW'(timeout_i);

  always_comb begin
    st_n = st_q;
    dl_n = dl_q;
    if (en_wr_i) st_n.en = en_val_i;
    if (refresh_i) begin
      dl_n    = reload;
      st_n.st1 = 1'b0;
      st_n.st2 = 1'b0;
    end else if (dl_wr_i) begin
      dl_n = dl_val_i;
    end else if (hit) begin
      if (!st_q.st1) begin
        st_n.st1 = 1'b1;
        dl_n     = reload;
      end else begin
        st_n.st2 = 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q  <= '0;
      dl_q  <= '0;
      irq_q <= 1'b0;
      rst_q <= 1'b0;
    end else begin
      st_q  <= st_n;
      dl_q  <= dl_n;
      irq_q <= st_n.st1 && st_n.en;
      rst_q <= rst_q || st_n.st2;
    end
  end

  assign state_o     = st_q;
  assign deadline_o  = dl_q;
  assign irq_o       = irq_q;
  assign wdt_reset_o = rst_q;

  p_refresh_clears_r2: assert property (@(posedge clk) disable iff (rst)
    refresh_i |=> !st_q.st1 && !st_q.st2);

  p_first_stage_r4: assert property (@(posedge clk) disable iff (rst)
    (hit && !st_q.st1 && !refresh_i && !dl_wr_i) |=> st_q.st1 && (irq_o == st_q.en));

  p_second_after_first_r5: assert property (@(posedge clk) disable iff (rst)
    $rose(st_q.st2) |-> $past(st_q.st1));

  p_reset_sticky_r6: assert property (@(posedge clk) disable iff (rst)
    wdt_reset_o |=> wdt_reset_o);

  p_reset_with_st2_r6: assert property (@(posedge clk) disable iff (rst)
    st_q.st2 |-> wdt_reset_o);

  p_idle_when_off_r7: assert property (@(posedge clk) disable iff (rst)
    (!st_q.en && !refresh_i) |=> $stable(st_q.st1) && $stable(st_q.st2));

  p_deadline_write_r8: assert property (@(posedge clk) disable iff (rst)
    (dl_wr_i && !refresh_i) |=> $stable(st_q.st1) && $stable(st_q.st2) && deadline_o == $past(dl_val_i));
endmodule

// File: rtl/wdog2_top.sv
module wdog2_top
  import wdog2_pkg::*;
#(
  parameter int unsigned DW     = 32,
  parameter int unsigned CW     = 32,
  parameter int unsigned OW     = 32,
  parameter logic [DW-1:0] ID_VAL = 32'h0001_5A3B
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          ref_wr,
  input  logic [11:0]   ref_addr,
  output logic [DW-1:0] ref_rdata,
  input  logic          ctl_wr,
  input  logic [11:0]   ctl_addr,
  input  logic [DW-1:0] ctl_wdata,
  output logic [DW-1:0] ctl_rdata,
  input  logic [CW-1:0] sys_count,
  output logic          irq_o,
  output logic          wdt_reset_o
);
  wd_state_t     state;
  logic [CW-1:0] deadline, dl_val;
  logic [OW-1:0] timeout;
  logic          refresh, en_wr, en_val, dl_wr;

  wdog2_regs #(.DW(DW), .CW(CW), .OW(OW), .ID_VAL(ID_VAL)) u_regs (
    .clk(clk), .rst(rst),
    .ref_wr(ref_wr), .ref_addr(ref_addr), .ref_rdata(ref_rdata),
    .ctl_wr(ctl_wr), .ctl_addr(ctl_addr), .ctl_wdata(ctl_wdata), .ctl_rdata(ctl_rdata),
    .state_i(state), .deadline_i(deadline), .timeout_o(timeout),
    .refresh_o(refresh), .en_wr_o(en_wr), .en_val_o(en_val),
    .dl_wr_o(dl_wr), .dl_val_o(dl_val)
  );

  wdog2_timer #(.CW(CW), .OW(OW)) u_timer (
    .clk(clk), .rst(rst), .cnt_i(sys_count), .timeout_i(timeout),
    .refresh_i(refresh), .en_wr_i(en_wr), .en_val_i(en_val),
    .dl_wr_i(dl_wr), .dl_val_i(dl_val),
    .state_o(state), .deadline_o(deadline),
    .irq_o(irq_o), .wdt_reset_o(wdt_reset_o)
  );

  p_reset_clear_r1: assert property (@(posedge clk)
    $past(rst) |-> !irq_o && !wdt_reset_o && state == '0);
endmodule

// File: tb/wdog2_top_bench.sv
module wdog2_top_bench;
  localparam logic [31:0] IDV = 32'h0001_5A3B;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        ref_wr = 1'b0, ctl_wr = 1'b0;
  logic [11:0] ref_addr = '0, ctl_addr = '0;
  logic [31:0] ctl_wdata = '0, ref_rdata, ctl_rdata;
  logic [31:0] sys_count = '0;
  logic        irq_o, wdt_reset_o;
  int checks = 0, errors = 0;
  int cycles = 0;
  logic [31:0] rd;

  always #2.5 clk = ~clk;

  wdog2_top u_wdog2_top (
    .clk(clk), .rst(rst), .ref_wr(ref_wr), .ref_addr(ref_addr), .ref_rdata(ref_rdata),
    .ctl_wr(ctl_wr), .ctl_addr(ctl_addr), .ctl_wdata(ctl_wdata), .ctl_rdata(ctl_rdata),
    .sys_count(sys_count), .irq_o(irq_o), .wdt_reset_o(wdt_reset_o)
  );

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 100000) begin
      errors = errors + 1;
      $display("FAIL watchdog: run hung, actual %0d cycles expected fewer", cycles);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic step();
    @(posedge clk); #1;
  endtask

  task automatic chk(input logic ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks = checks + 1;
    if (!ok) begin
      errors = errors + 1;
      $display("FAIL %s actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic do_reset();
    rst = 1'b1; step(); step(); rst = 1'b0;
  endtask

  task automatic wr_ctl(input logic [11:0] a, input logic [31:0] d);
    ctl_addr = a; ctl_wdata = d; ctl_wr = 1'b1; step(); ctl_wr = 1'b0;
  endtask

  task automatic wr_ref();
    ref_addr = 12'h000; ref_wr = 1'b1; step(); ref_wr = 1'b0;
  endtask

  task automatic rd_ctl(input logic [11:0] a, output logic [31:0] d);
    ctl_addr = a; step(); d = ctl_rdata;
  endtask

  task automatic rd_ref(input logic [11:0] a, output logic [31:0] d);
    ref_addr = a; step(); d = ref_rdata;
  endtask

  task automatic tick_to(input logic [31:0] v);
    sys_count = v; step();
  endtask

  initial begin
    do_reset();
    // R1 reset state
    chk(irq_o == 1'b0, "R1 irq", {31'b0, irq_o}, 0);
    chk(wdt_reset_o == 1'b0, "R1 rst", {31'b0, wdt_reset_o}, 0);
    rd_ctl(12'h000, rd); chk(rd == 0, "R1 ctrl", rd, 0);
    rd_ctl(12'h008, rd); chk(rd == 0, "R1 timeout", rd, 0);
    // R10 ident both windows, unmapped
    rd_ctl(12'hFCC, rd); chk(rd == IDV, "R10 ctl ident", rd, IDV);
    rd_ref(12'hFCC, rd); chk(rd == IDV, "R10 ref ident", rd, IDV);
    wr_ctl(12'hFCC, 32'hDEAD_BEEF);
    rd_ctl(12'hFCC, rd); chk(rd == IDV, "R10 ident ro", rd, IDV);
    rd_ctl(12'h020, rd); chk(rd == 0, "R10 unmapped", rd, 0);

    // R4/R5 sweep: expiry times from refresh at base b
    for (int o = 1; o <= 8; o++) begin
      for (int bi = 0; bi < 2; bi++) begin
        logic [31:0] b;
        b = (bi == 0) ? 32'd100 : 32'd50000;
        do_reset();
        sys_count = b;
        wr_ctl(12'h008, o);
        wr_ctl(12'h000, 32'h1);
        for (int k = 1; k <= 2 * o + 1; k++) begin
          tick_to(b + k);
          chk(irq_o == (k >= o), "R4 irq timing", {31'b0, irq_o}, {31'b0, (k >= o)});
          chk(wdt_reset_o == (k >= 2 * o), "R5 reset timing", {31'b0, wdt_reset_o}, {31'b0, (k >= 2 * o)});
        end
      end
    end

    // R9 timeout readback and status layout
    do_reset();
    sys_count = 1000;
    wr_ctl(12'h008, 32'd4);
    rd_ctl(12'h008, rd); chk(rd == 4, "R9 timeout read", rd, 4);
    wr_ctl(12'h000, 32'h1);
    rd_ctl(12'h000, rd); chk(rd == 32'h1, "R9 ctrl enabled", rd, 1);
    rd_ctl(12'h010, rd); chk(rd == 1004, "R2 deadline from ctl refresh", rd, 1004);
    tick_to(1004);
    chk(irq_o == 1'b1, "R4 irq set", {31'b0, irq_o}, 1);
    rd_ctl(12'h000, rd); chk(rd == 32'h3, "R9 ctrl st1", rd, 3);
    // R2 refresh window
    wr_ref();
    chk(irq_o == 1'b0, "R2 refresh clears irq", {31'b0, irq_o}, 0);
    rd_ctl(12'h000, rd); chk(rd == 32'h1, "R2 flags cleared", rd, 1);
    tick_to(1007); chk(irq_o == 1'b0, "R2 not before deadline", {31'b0, irq_o}, 0);
    tick_to(1008); chk(irq_o == 1'b1, "R2 new deadline", {31'b0, irq_o}, 1);
    // R3 flag bits in data ignored, disable
    wr_ctl(12'h000, 32'h6);
    rd_ctl(12'h000, rd); chk(rd == 0, "R3 flags not writable", rd, 0);
    chk(irq_o == 1'b0, "R3 irq low", {31'b0, irq_o}, 0);
    // R7 disabled: no expiry
    tick_to(5000); tick_to(9000); tick_to(9001);
    rd_ctl(12'h000, rd); chk(rd == 0, "R7 no flags when off", rd, 0);
    chk(irq_o == 1'b0 && wdt_reset_o == 1'b0, "R7 outputs low", {30'b0, wdt_reset_o, irq_o}, 0);

    // R8 deadline write, then R5/R6
    do_reset();
    sys_count = 2000;
    wr_ctl(12'h008, 32'd4);
    wr_ctl(12'h000, 32'h1);
    tick_to(2004); chk(irq_o == 1'b1, "R4 st1 at 2004", {31'b0, irq_o}, 1);
    wr_ctl(12'h010, 32'd2100);
    rd_ctl(12'h000, rd); chk(rd == 32'h3, "R8 flags kept", rd, 3);
    rd_ctl(12'h010, rd); chk(rd == 2100, "R8 deadline loaded", rd, 2100);
    chk(irq_o == 1'b1, "R8 irq kept", {31'b0, irq_o}, 1);
    tick_to(2099); chk(wdt_reset_o == 1'b0, "R8 no reset early", {31'b0, wdt_reset_o}, 0);
    tick_to(2100); chk(wdt_reset_o == 1'b1, "R5 reset at deadline", {31'b0, wdt_reset_o}, 1);
    rd_ctl(12'h000, rd); chk(rd == 32'h7, "R9 ctrl st2", rd, 7);
    wr_ref();
    chk(wdt_reset_o == 1'b1, "R6 sticky after refresh", {31'b0, wdt_reset_o}, 1);
    rd_ctl(12'h000, rd); chk(rd == 32'h1, "R6 flags cleared", rd, 1);
    wr_ctl(12'h000, 32'h0);
    chk(wdt_reset_o == 1'b1, "R6 sticky after disable", {31'b0, wdt_reset_o}, 1);
    do_reset();
    chk(wdt_reset_o == 1'b0, "R1 reset clears request", {31'b0, wdt_reset_o}, 0);

    // R11 refresh wins over expiry in the same cycle
    sys_count = 3000;
    wr_ctl(12'h008, 32'd4);
    wr_ctl(12'h000, 32'h1);
    tick_to(3003);
    sys_count = 3004; wr_ref();
    chk(irq_o == 1'b0, "R11 refresh beats expiry", {31'b0, irq_o}, 0);
    rd_ctl(12'h010, rd); chk(rd == 3008, "R11 deadline", rd, 3008);
    tick_to(3007); chk(irq_o == 1'b0, "R11 before", {31'b0, irq_o}, 0);
    tick_to(3008); chk(irq_o == 1'b1, "R11 at deadline", {31'b0, irq_o}, 1);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule